// File: doc/BRIEF.md
# Palettized Pixel Fetch and Serializer

This block turns a stream of 64-bit frame-memory words into a colored pixel stream for a graphics display that uses one byte per pixel. Each memory word holds eight pixel indices. The block keeps two word registers. The use register shifts out one index per pixel clock. Meanwhile the staging register waits with the next word, so the memory round trip is hidden behind eight pixel times. Every index selects one of 256 palette entries. Each entry is a 12-bit color, so the palette can draw from 4096 colors, and the looked-up value drives a 4:4:4 RGB output.

Timing generation sits outside the block. It pulses `lineStart` during blanking ahead of each visible line and holds `activeIn` high for the visible pixels. On the line pulse the block discards what it holds and fetches two fresh words. The first visible pixel is therefore ready on time. A host loads the palette through a simple write port. Memory is reached through a one-cycle request pulse, answered some cycles later by a one-cycle valid strobe that carries the word.

Top module: `palPixelSerializer`

## Requirements
- R1: After reset, `rgbOut`, `activeOut`, `underflow` and `memReq` are 0, and no request is issued before the first `lineStart` pulse.
- R2: Within a 64-bit word, pixels leave least significant byte first (bits 7:0, then 15:8, up to 63:56). Words are shown in the order memory delivered them.
- R3: Each visible pixel appears on `rgbOut` one clock after its `activeIn` cycle, as the 12-bit palette entry selected by its byte. Red is in bits 11:8, green in 7:4 and blue in 3:0.
- R4: `activeOut` equals `activeIn` delayed by one clock. `rgbOut` is 0 whenever `activeOut` is 0.
- R5: A `lineStart` pulse flushes both word registers and fetches two words. When `activeIn` rises at least 40 clocks after the pulse (memory latency up to 12 clocks), the first pixel of the line is byte 0 of the first word delivered after the pulse.
- R6: `memReq` is a single pulse, issued only when the staging register is empty and no read is outstanding, so at most one read is in flight.
- R7: If a visible pixel is due while the use register is empty, `underflow` rises and stays high until the next `lineStart`. From that pixel on, `rgbOut` is 0.
- R8: A read still outstanding when `lineStart` arrives is discarded when it returns, and it is never displayed.
- R9: When the last byte of the use register is shown, the staging word moves in on the same clock. The pixels of consecutive words follow with no gap.
- R10: Palette writes take effect for lookups made after the write clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle pulse in blanking before a visible line |
| activeIn | input | 1 | High for each visible pixel |
| memReq | output | 1 | One-cycle read request for the next word |
| memValid | input | 1 | One-cycle strobe qualifying `memData` |
| memData | input | 64 | Word returned by frame memory |
| palWrEn | input | 1 | Palette write enable |
| palWrAddr | input | 8 | Palette entry to write |
| palWrData | input | 12 | Color value, R in 11:8, G in 7:4, B in 3:0 |
| activeOut | output | 1 | `activeIn` aligned to `rgbOut` |
| rgbOut | output | 12 | Pixel color, zero outside visible pixels |
| underflow | output | 1 | Sticky flag: a pixel was due with no data |

## Verification
The checker relies on three properties of the environment. Memory answers each request with exactly one valid strobe. `lineStart` arrives only while `activeIn` is low. `activeIn` never rises in the same cycle as `lineStart`. The bench memory model responds only to sampled requests, and it keeps a fixed latency that is changed only while the block is idle. The sequencer keeps line pulses inside blanking, with idle gaps long enough for fetches to finish. Under those rules, the outstanding-read count that the checker derives from the ports stays at one or below.

// File: rtl/pixSerPkg.sv
package pixSerPkg;

  // Strobes from the control into the datapath and palette stage
  typedef struct packed {
    logic loadStage;   // capture returning memory word in staging
    logic moveToUse;   // copy staging word into use register
    logic shiftUse;    // drop the byte just shown
    logic pixValid;    // current index is a real visible pixel
  } ctrlStrobes_t;

endpackage

// File: rtl/pixFetchCtrl.sv
module pixFetchCtrl
  import pixSerPkg::*;
#(
  parameter int WORD_PIX = 8,
  localparam int CNT_W = $clog2(WORD_PIX + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         lineStart,
  input  logic         activeIn,
  input  logic         memValid,
  output logic         memReq,
  output ctrlStrobes_t strobes,
  output logic         underflow
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_PIX);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] useCount;
  logic stageValid;
  logic pending;
  logic dropNext;
  logic fetchEn;
  logic uflow;

  logic consume;
  logic arrive;
  logic keepWord;
  logic useDrains;

  always_comb begin
    consume   = activeIn && (useCount != '0);
    arrive    = memValid && pending;
    keepWord  = arrive && !dropNext;
    useDrains = (useCount == '0) || (consume && (useCount == ONE_CNT));

    strobes.moveToUse = stageValid && useDrains && !lineStart;
    strobes.loadStage = keepWord && !lineStart;
    strobes.shiftUse  = consume;
    strobes.pixValid  = consume && !uflow;

    memReq = fetchEn && !pending && !stageValid && !lineStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      useCount   <= '0;
      stageValid <= 1'b0;
      pending    <= 1'b0;
      dropNext   <= 1'b0;
      fetchEn    <= 1'b0;
      uflow      <= 1'b0;
    end else if (lineStart) begin
      useCount   <= '0;
      stageValid <= 1'b0;
      uflow      <= 1'b0;
      fetchEn    <= 1'b1;
      pending    <= pending && !arrive;
      dropNext   <= pending && !arrive;
    end else begin
      if (memReq)       pending <= 1'b1;
      else if (arrive)  pending <= 1'b0;

      if (arrive) dropNext <= 1'b0;

      if (strobes.loadStage)      stageValid <= 1'b1;
      else if (strobes.moveToUse) stageValid <= 1'b0;

      if (strobes.moveToUse) useCount <= FULL_CNT;
      else if (consume)      useCount <= useCount - ONE_CNT;

      if (activeIn && (useCount == '0)) uflow <= 1'b1;
    end
  end

  assign underflow = uflow;

endmodule

// File: rtl/pixFetchPath.sv
module pixFetchPath
  import pixSerPkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int WORD_PIX = 8,
  localparam int WORD_W  = PIX_W * WORD_PIX
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] memData,
  output logic [PIX_W-1:0]  pixIdx
);

  logic [WORD_W-1:0] stageReg;
  logic [WORD_W-1:0] useReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageReg <= '0;
      useReg   <= '0;
    end else begin
      if (strobes.loadStage) stageReg <= memData;

      if (strobes.moveToUse)     useReg <= stageReg;
      else if (strobes.shiftUse) useReg <= useReg >> PIX_W;
    end
  end

  // Low byte of the use register is always the next pixel
  assign pixIdx = useReg[PIX_W-1:0];

endmodule

// File: rtl/pixPalette.sv
module pixPalette
  import pixSerPkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COLOR_W = 12,
  localparam int DEPTH  = 1 << PIX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [PIX_W-1:0]   pixIdx,
  input  logic               activeIn,
  input  logic               palWrEn,
  input  logic [PIX_W-1:0]   palWrAddr,
  input  logic [COLOR_W-1:0] palWrData,
  output logic               activeOut,
  output logic [COLOR_W-1:0] rgbOut
);

  logic [COLOR_W-1:0] palMem [DEPTH];

  always_ff @(posedge clk) begin
    if (palWrEn) palMem[palWrAddr] <= palWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rgbOut    <= '0;
      activeOut <= 1'b0;
    end else begin
      rgbOut    <= strobes.pixValid ? palMem[pixIdx] : '0;
      activeOut <= activeIn;
    end
  end

endmodule

// File: rtl/palPixelSerializer.sv
module palPixelSerializer
  import pixSerPkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int WORD_PIX = 8,
  parameter int COLOR_W  = 12,
  localparam int WORD_W  = PIX_W * WORD_PIX
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineStart,
  input  logic               activeIn,
  output logic               memReq,
  input  logic               memValid,
  input  logic [WORD_W-1:0]  memData,
  input  logic               palWrEn,
  input  logic [PIX_W-1:0]   palWrAddr,
  input  logic [COLOR_W-1:0] palWrData,
  output logic               activeOut,
  output logic [COLOR_W-1:0] rgbOut,
  output logic               underflow
);

  ctrlStrobes_t      strobes;
  logic [PIX_W-1:0]  pixIdx;

  pixFetchCtrl #(.WORD_PIX(WORD_PIX)) uCtrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .activeIn(activeIn),
    .memValid(memValid), .memReq(memReq), .strobes(strobes),
    .underflow(underflow)
  );

  pixFetchPath #(.PIX_W(PIX_W), .WORD_PIX(WORD_PIX)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memData(memData),
    .pixIdx(pixIdx)
  );

  pixPalette #(.PIX_W(PIX_W), .COLOR_W(COLOR_W)) uPal (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pixIdx(pixIdx),
    .activeIn(activeIn), .palWrEn(palWrEn), .palWrAddr(palWrAddr),
    .palWrData(palWrData), .activeOut(activeOut), .rgbOut(rgbOut)
  );

endmodule

// File: rtl/palPixelSerializerChk.sv
module palPixelSerializerChk #(
  parameter int COLOR_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               lineStart,
  input logic               activeIn,
  input logic               memReq,
  input logic               memValid,
  input logic               activeOut,
  input logic [COLOR_W-1:0] rgbOut,
  input logic               underflow
);

  logic       seenLine;
  logic [1:0] inFlight;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenLine <= 1'b0;
      inFlight <= '0;
    end else begin
      if (lineStart) seenLine <= 1'b1;
      inFlight <= inFlight + {1'b0, memReq} - {1'b0, memValid && (inFlight != '0)};
    end
  end

  // R1: no fetch before the first line pulse
  a_r1_no_req_before_line: assert property (@(posedge clk) disable iff (!rstN)
    !seenLine |-> !memReq);

  // R6: a request only with nothing in flight
  a_r6_single_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (inFlight == '0));

  // R4: active delayed by one clock
  a_r4_active_rise: assert property (@(posedge clk) disable iff (!rstN)
    activeIn |=> activeOut);
  a_r4_active_fall: assert property (@(posedge clk) disable iff (!rstN)
    !activeIn |=> !activeOut);

  // R4: black outside visible pixels
  a_r4_black_idle: assert property (@(posedge clk) disable iff (!rstN)
    !activeOut |-> (rgbOut == '0));

  // R7: flag holds until a line pulse
  a_r7_uflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !lineStart) |=> underflow);

  // R7: black while flagged
  a_r7_black_after_uflow: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> (rgbOut == '0));

endmodule

bind palPixelSerializer palPixelSerializerChk #(.COLOR_W(COLOR_W)) chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .activeIn(activeIn),
  .memReq(memReq), .memValid(memValid), .activeOut(activeOut),
  .rgbOut(rgbOut), .underflow(underflow)
);

// File: tb/palPixelSerializer_test.sv
`timescale 1ns/100ps
module palPixelSerializer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic        activeIn = 1'b0;
  logic        memReq;
  logic        memValid = 1'b0;
  logic [63:0] memData = '0;
  logic        palWrEn = 1'b0;
  logic [7:0]  palWrAddr = '0;
  logic [11:0] palWrData = '0;
  logic        activeOut;
  logic [11:0] rgbOut;
  logic        underflow;

  int checks = 0;
  int errors = 0;
  int served = 0;
  int lat = 4;
  int cnt = 0;
  int reqClash = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  palPixelSerializer uut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .activeIn(activeIn),
    .memReq(memReq), .memValid(memValid), .memData(memData),
    .palWrEn(palWrEn), .palWrAddr(palWrAddr), .palWrData(palWrData),
    .activeOut(activeOut), .rgbOut(rgbOut), .underflow(underflow)
  );

  function automatic logic [7:0] pixByte(int w, int b);
    return 8'((w * 8 + b) * 7 + 11);
  endfunction

  function automatic logic [63:0] mkWord(int w);
    logic [63:0] v;
    for (int b = 0; b < 8; b++) v[b*8 +: 8] = pixByte(w, b);
    return v;
  endfunction

  function automatic logic [11:0] palVal(int gen, int i);
    return 12'(i * 149 + gen * 935 + 1443);
  endfunction

  // Memory responder: fixed latency, one word per request
  always @(posedge clk) begin
    if (cnt == 1) begin
      memValid <= 1'b1;
      memData  <= mkWord(served);
      served   <= served + 1;
    end else begin
      memValid <= 1'b0;
    end
    if (memReq) begin
      if (cnt != 0) reqClash <= reqClash + 1;
      cnt <= lat;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadPalette(int gen);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      palWrEn = 1'b1; palWrAddr = 8'(i); palWrData = palVal(gen, i);
    end
    @(negedge clk);
    palWrEn = 1'b0;
  endtask

  task automatic pulseLine();
    @(negedge clk);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
  endtask

  // Drive nPix visible pixels and compare each one clock later
  task automatic runLine(int nPix, int firstWord, int uflowAt, int gen, string req);
    logic [11:0] exp;
    for (int p = 0; p <= nPix; p++) begin
      @(negedge clk);
      if (p > 0) begin
        int q = p - 1;
        if (uflowAt >= 0 && q >= uflowAt) exp = '0;
        else exp = palVal(gen, int'(pixByte(firstWord + q / 8, q % 8)));
        chk(req, 32'(rgbOut), 32'(exp));
        chk("R4 activeOut high", 32'(activeOut), 32'd1);
      end
      activeIn = (p < nPix);
    end
    @(negedge clk);
    chk("R4 activeOut low after line", 32'(activeOut), 32'd0);
    chk("R4 black after line", 32'(rgbOut), 32'd0);
  endtask

  initial begin
    int fw;
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int fw;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state and idle before any line pulse
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R1 memReq idle", 32'(memReq), 32'd0);
    end
    chk("R1 rgbOut", 32'(rgbOut), 32'd0);
    chk("R1 activeOut", 32'(activeOut), 32'd0);
    chk("R1 underflow", 32'(underflow), 32'd0);

    loadPalette(0);

    // R2 R3 R5 R9: full sweep of all 256 indices
    fw = served;
    pulseLine();
    repeat (40) @(negedge clk);
    chk("R4 black in blanking", 32'(rgbOut), 32'd0);
    runLine(256, fw, -1, 0, "R2 R3 R9 pixel sweep");
    repeat (20) @(negedge clk);

    // R5: second line restarts at a fresh word
    fw = served;
    pulseLine();
    repeat (40) @(negedge clk);
    runLine(40, fw, -1, 0, "R5 line restart");
    repeat (20) @(negedge clk);

    // R10: new palette contents
    loadPalette(1);
    fw = served;
    pulseLine();
    repeat (40) @(negedge clk);
    runLine(64, fw, -1, 1, "R10 palette rewrite");
    repeat (20) @(negedge clk);

    // R8: line pulse while a read is in flight
    @(negedge clk);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    while (memReq !== 1'b1) @(negedge clk);
    @(negedge clk);
    lineStart = 1'b1;
    fw = served + 1;
    @(negedge clk);
    lineStart = 1'b0;
    repeat (40) @(negedge clk);
    runLine(24, fw, -1, 1, "R8 stale word dropped");
    chk("R8 no underflow", 32'(underflow), 32'd0);
    repeat (20) @(negedge clk);

    // R7: slow memory starves the third word
    lat = 12;
    repeat (20) @(negedge clk);
    fw = served;
    pulseLine();
    repeat (60) @(negedge clk);
    chk("R7 clear before line", 32'(underflow), 32'd0);
    runLine(40, fw, 16, 1, "R7 underflow blanking");
    chk("R7 underflow raised", 32'(underflow), 32'd1);
    repeat (30) @(negedge clk);
    chk("R7 underflow held", 32'(underflow), 32'd1);
    lat = 4;
    repeat (20) @(negedge clk);
    fw = served;
    pulseLine();
    chk("R7 cleared by line", 32'(underflow), 32'd0);
    repeat (40) @(negedge clk);
    runLine(16, fw, -1, 1, "R7 recovery line");
    chk("R7 stays clear", 32'(underflow), 32'd0);

    chk("R6 single read in flight", 32'(reqClash), 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule